// File: doc/BRIEF.md
# Bus Event Performance Counter Block

This block sits beside a bus crossbar and counts traffic events on its downstream ports. It has four counters, and each counter has its own select register. The select register chooses one of twenty single-cycle event inputs. The events come in pairs, one pair for each of ten downstream ports. In each pair, one input pulses only when an access to that port had to wait for another initiator (contested). The other input pulses on every access to that port.

Software uses an APB slave interface to configure and read the block. It writes a select code to choose an event. It reads a counter to see how many selected events have happened since the last clear. Writing any value to a counter clears it. A counter stops at its all-ones value and does not wrap, so an overflowed measurement is visible as full scale. The select reset value is outside the valid event range, so the counters stay idle until software configures them.

Top module: `bus_evt_perf_ctr`

## Requirements
- R1: After reset, every counter reads zero, every select register reads 0x1F, and `pready` is 1.
- R2: Counter i holds its value unless an event arrives. At each rising clock edge where bit s of `evt_pulse` is 1 and s is the code in select register i, counter i increases by one. Bit 2p is the contested event of port p, and bit 2p+1 is the every-access event of port p. Ports 0 to 9 are, in order: APB peripherals, fast peripherals, SRAM bank 5, bank 4, bank 3, bank 2, bank 1, bank 0, main execute-in-place flash, ROM.
- R3: A counter that reaches all ones (CTR_W bits, 24 by default) stays at all ones while more events arrive.
- R4: An APB write of any data value to a counter register sets that counter to zero. If a selected event arrives in the same cycle as the clear, the clear wins.
- R5: Select codes 0x14 to 0x1F, including the reset value, choose no event, and the counter does not change.
- R6: A write to a select register stores bits 4:0 of the write data. A read returns those bits, and bits 31:5 read as zero. A counter read returns its value in bits CTR_W-1:0, and the bits above read as zero.
- R7: A new select code applies from the clock edge after the edge that writes it. The edge that writes it still uses the old code. Changing the select does not clear the counter.
- R8: Register layout: counter i is at byte offset 0x08+8i and select i is at 0x0C+8i. Any other offset, including offsets that are not word aligned, reads zero, and writes to it change no register.
- R9: Each counter is independent of the others. Two counters with the same select code count the same events, and clearing one does not change the other.
- R10: Transfers complete with zero wait states. `pready` is always 1, and read data is valid during the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W (12) | Byte offset of the register |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data; zero when no read is in progress |
| pready | output | 1 | Always 1 |
| evt_pulse | input | 2*NUM_PORTS (20) | Single-cycle event pulses, with bit index equal to the select code |

## Verification
A wrong counter value has no separate status output. It shows up only in the next read of that counter, and for saturation or a same-cycle clear only once enough events have arrived to reach that condition. A wrong select decode shows as the wrong count in the same read. The bench therefore reads every counter right after each event burst, so an error shows up within a few cycles of the stimulus that caused it. Reserved codes, the order of a select change against an event, and unmapped offsets are each checked by a read in which a wrong design returns a count that differs from the expected one.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  // Byte offset of the first counter, and the distance between register pairs.
  localparam int unsigned CTR_BASE_OFF = 8;
  localparam int unsigned PAIR_STRIDE  = 8;
  localparam int unsigned SEL_REL_OFF  = 4;

  // Which kind of register one address points to, for one pair slot.
  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_COUNT,
    HIT_SELECT
  } reg_kind_e;

  function automatic int unsigned count_offset(int unsigned idx);
    return CTR_BASE_OFF + PAIR_STRIDE * idx;
  endfunction

  function automatic int unsigned select_offset(int unsigned idx);
    return count_offset(idx) + SEL_REL_OFF;
  endfunction

  // Event code of one port: even code = contested, odd code = every access.
  function automatic int unsigned event_code(int unsigned port, bit every_access);
    return 2 * port + (every_access ? 1 : 0);
  endfunction

endpackage

// File: rtl/perf_apb_decode.sv
module perf_apb_decode
  import perf_ctr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_CTR = 4
) (
  input  logic [ADDR_W-1:0]  paddr,
  output logic [NUM_CTR-1:0] ctr_hit,
  output logic [NUM_CTR-1:0] sel_hit
);

  // Find which register of pair idx the address points to. The full
  // address must match, so an offset that is not word aligned hits nothing.
  function automatic reg_kind_e classify(logic [ADDR_W-1:0] a, int unsigned idx);
    if (a == ADDR_W'(count_offset(idx)))  return HIT_COUNT;
    if (a == ADDR_W'(select_offset(idx))) return HIT_SELECT;
    return HIT_NONE;
  endfunction

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
    reg_kind_e kind;
    assign kind       = classify(paddr, g);
    assign ctr_hit[g] = (kind == HIT_COUNT);
    assign sel_hit[g] = (kind == HIT_SELECT);
  end

endmodule

// File: rtl/perf_evt_select.sv
module perf_evt_select #(
  parameter int unsigned NUM_EVT = 20,
  parameter int unsigned SEL_W   = 5
) (
  input  logic [NUM_EVT-1:0] evt,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);

  // A code at or above NUM_EVT matches no input, so the result is 0.
  function automatic logic pick(logic [NUM_EVT-1:0] e, logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (s == SEL_W'(k)) r = e[k];
    end
    return r;
  endfunction

  assign hit = pick(evt, sel);

endmodule

// File: rtl/perf_sat_counter.sv
module perf_sat_counter #(
  parameter int unsigned CTR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CTR_W-1:0] count
);

  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  // A clear takes priority over an increment, and the count stops at CTR_MAX.
  function automatic logic [CTR_W-1:0] next_count(logic [CTR_W-1:0] cur,
                                                  logic do_clr, logic do_inc);
    if (do_clr)                   return '0;
    if (do_inc && cur != CTR_MAX) return cur + CTR_W'(1);
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, clr, inc);
  end

endmodule

// File: rtl/bus_evt_perf_ctr.sv
module bus_evt_perf_ctr #(
  parameter int unsigned NUM_CTR   = 4,
  parameter int unsigned NUM_PORTS = 10,
  parameter int unsigned CTR_W     = 24,
  parameter int unsigned SEL_W     = 5,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                   pclk,
  input  logic                   presetn,
  input  logic                   psel,
  input  logic                   penable,
  input  logic                   pwrite,
  input  logic [ADDR_W-1:0]      paddr,
  input  logic [DATA_W-1:0]      pwdata,
  output logic [DATA_W-1:0]      prdata,
  output logic                   pready,
  input  logic [2*NUM_PORTS-1:0] evt_pulse
);

  localparam int unsigned NUM_EVT = 2 * NUM_PORTS;
  localparam logic [SEL_W-1:0] SEL_RESET = {SEL_W{1'b1}};

  // Internal events, given names so the bound checker can see them.
  logic                              wr_access;
  logic                              rd_access;
  logic [NUM_CTR-1:0]                ctr_hit;
  logic [NUM_CTR-1:0]                sel_hit;
  logic [NUM_CTR-1:0]                ctr_clr;
  logic [NUM_CTR-1:0]                sel_wr;
  logic [NUM_CTR-1:0]                ctr_evt;
  logic [NUM_CTR-1:0][CTR_W-1:0]     ctr_val;
  logic [NUM_CTR-1:0][SEL_W-1:0]     sel_q;
  logic [DATA_W-1:0]                 rdata_mux;
  logic                              wdata_unused;

  assign wr_access    = psel & penable & pwrite;
  assign rd_access    = psel & ~pwrite;
  assign pready       = 1'b1;
  assign wdata_unused = ^pwdata[DATA_W-1:SEL_W];

  perf_apb_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_CTR (NUM_CTR)
  ) decode_i (
    .paddr   (paddr),
    .ctr_hit (ctr_hit),
    .sel_hit (sel_hit)
  );

  assign ctr_clr = {NUM_CTR{wr_access}} & ctr_hit;
  assign sel_wr  = {NUM_CTR{wr_access}} & sel_hit;

  // Select registers: written in one process so the array has one driver.
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int i = 0; i < NUM_CTR; i++) sel_q[i] <= SEL_RESET;
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (sel_wr[i]) sel_q[i] <= pwdata[SEL_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    perf_evt_select #(
      .NUM_EVT (NUM_EVT),
      .SEL_W   (SEL_W)
    ) mux_i (
      .evt (evt_pulse),
      .sel (sel_q[g]),
      .hit (ctr_evt[g])
    );

    perf_sat_counter #(
      .CTR_W (CTR_W)
    ) cnt_i (
      .clk   (pclk),
      .rst_n (presetn),
      .clr   (ctr_clr[g]),
      .inc   (ctr_evt[g]),
      .count (ctr_val[g])
    );
  end

  // Read mux: at most one hit line is active, so OR-ing the terms is safe.
  always_comb begin
    rdata_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (ctr_hit[i]) rdata_mux = rdata_mux | DATA_W'(ctr_val[i]);
      if (sel_hit[i]) rdata_mux = rdata_mux | DATA_W'(sel_q[i]);
    end
  end

  assign prdata = rd_access ? rdata_mux : '0;

endmodule

// File: rtl/perf_ctr_checker.sv
module perf_ctr_checker #(
  parameter int unsigned NUM_CTR = 4,
  parameter int unsigned CTR_W   = 24,
  parameter int unsigned SEL_W   = 5,
  parameter int unsigned NUM_EVT = 20
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          pready,
  input logic [NUM_CTR-1:0]            ctr_clr,
  input logic [NUM_CTR-1:0]            sel_wr,
  input logic [NUM_CTR-1:0]            ctr_evt,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val,
  input logic [NUM_CTR-1:0][SEL_W-1:0] sel_val
);

  localparam logic [CTR_W-1:0] FULL = {CTR_W{1'b1}};

  assert_pready_high_R10: assert property (@(posedge clk) disable iff (!rst_n) pready);

  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctr_clr, sel_wr}));

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_clr[g] |=> ctr_val[g] == '0);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_val[g] == FULL && !ctr_clr[g]) |=> ctr_val[g] == FULL);

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_evt[g] && !ctr_clr[g] && ctr_val[g] != FULL)
      |=> ctr_val[g] == $past(ctr_val[g]) + CTR_W'(1));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctr_evt[g] && !ctr_clr[g]) |=> $stable(ctr_val[g]));

    assert_reserved_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_val[g]) >= NUM_EVT) |-> !ctr_evt[g]);

    assert_select_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr[g] && !ctr_clr[g] && !ctr_evt[g]) |=> $stable(ctr_val[g]));
  end

endmodule

bind bus_evt_perf_ctr perf_ctr_checker #(
  .NUM_CTR (NUM_CTR),
  .CTR_W   (CTR_W),
  .SEL_W   (SEL_W),
  .NUM_EVT (NUM_EVT)
) chk_i (
  .clk     (pclk),
  .rst_n   (presetn),
  .pready  (pready),
  .ctr_clr (ctr_clr),
  .sel_wr  (sel_wr),
  .ctr_evt (ctr_evt),
  .ctr_val (ctr_val),
  .sel_val (sel_q)
);

// File: tb/bus_evt_perf_ctr_tb_top.sv
module bus_evt_perf_ctr_tb_top;

  localparam int NUM_CTR   = 4;
  localparam int NUM_PORTS = 10;
  localparam int NUM_EVT   = 2 * NUM_PORTS;
  localparam int CTR_W     = 6;   // small width so saturation is reached quickly
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CMAX      = (1 << CTR_W) - 1;

  logic               pclk    = 1'b0;
  logic               presetn = 1'b0;
  logic               psel    = 1'b0;
  logic               penable = 1'b0;
  logic               pwrite  = 1'b0;
  logic [ADDR_W-1:0]  paddr   = '0;
  logic [DATA_W-1:0]  pwdata  = '0;
  logic [NUM_EVT-1:0] evt     = '0;
  logic [DATA_W-1:0]  prdata;
  logic               pready;

  always #10 pclk = ~pclk;   // 50 MHz

  bus_evt_perf_ctr #(
    .NUM_CTR   (NUM_CTR),
    .NUM_PORTS (NUM_PORTS),
    .CTR_W     (CTR_W)
  ) dut_i (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pready    (pready),
    .evt_pulse (evt)
  );

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  int exp_cnt[NUM_CTR];
  int exp_sel[NUM_CTR];

  function automatic int ctr_addr(int i); return 8 + 8 * i;  endfunction
  function automatic int sel_addr(int i); return 12 + 8 * i; endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: compares each read in its access phase with the queued expectation.
  initial begin
    forever begin
      @(negedge pclk);
      #5;
      if (psel && penable && !pwrite) begin
        if (exp_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R10 unexpected read: actual 0x%08h expected none", prdata);
        end else begin
          logic [DATA_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, prdata, e);
          check({t, " pready R10"}, DATA_W'(pready), 1);
        end
      end
    end
  end

  // Events given in mask are high for the write edge and the edge after it.
  task automatic apb_write(int addr, logic [DATA_W-1:0] data, logic [NUM_EVT-1:0] mask);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = ADDR_W'(addr); pwdata = data;
    @(negedge pclk);
    penable = 1'b1; evt = mask;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    evt = '0;
  endtask

  task automatic apb_read(int addr, logic [DATA_W-1:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = ADDR_W'(addr);
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // Drive mask for n rising edges and update the reference model.
  task automatic pulse(logic [NUM_EVT-1:0] mask, int n);
    @(negedge pclk);
    evt = mask;
    repeat (n) @(negedge pclk);
    evt = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (exp_sel[i] < NUM_EVT && mask[exp_sel[i]]) begin
        exp_cnt[i] = (exp_cnt[i] + n > CMAX) ? CMAX : exp_cnt[i] + n;
      end
    end
  endtask

  task automatic set_sel(int i, logic [DATA_W-1:0] data);
    apb_write(sel_addr(i), data, '0);
    exp_sel[i] = int'(data[4:0]);
  endtask

  task automatic clr_ctr(int i, logic [DATA_W-1:0] data);
    apb_write(ctr_addr(i), data, '0);
    exp_cnt[i] = 0;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < NUM_CTR; i++) begin
      apb_read(ctr_addr(i), DATA_W'(exp_cnt[i]), $sformatf("%s ctr%0d", tag, i));
      apb_read(sel_addr(i), DATA_W'(exp_sel[i]), $sformatf("%s sel%0d", tag, i));
    end
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM_CTR; i++) begin
      exp_cnt[i] = 0;
      exp_sel[i] = 31;
    end
    repeat (3) @(negedge pclk);
    presetn = 1'b1;

    // R1: reset values
    check("R1 pready after reset", DATA_W'(pready), 1);
    read_all("R1 reset");

    // R5: reset select code and 0x14 count nothing
    pulse('1, 5);
    set_sel(0, 32'h14);
    pulse('1, 3);
    read_all("R5 reserved codes");

    // R2: mapping of codes to events
    set_sel(0, 32'h00);   // port 0 contested
    set_sel(1, 32'h01);   // port 0 every access
    set_sel(2, 32'h13);   // ROM every access
    set_sel(3, 32'h0E);   // SRAM bank 0 contested
    pulse(NUM_EVT'(1) << 0, 3);
    pulse(NUM_EVT'(1) << 1, 5);
    pulse(NUM_EVT'(1) << 19, 2);
    pulse(NUM_EVT'(1) << 14, 4);
    pulse(NUM_EVT'(1) << 15, 7);   // not selected anywhere
    read_all("R2 event mapping");

    // R6: select keeps low five bits only
    set_sel(1, 32'hFFFF_FFE7);
    apb_read(sel_addr(1), 32'h7, "R6 select width");

    // R9: two counters on one event, clear one
    set_sel(0, 32'h05);
    set_sel(1, 32'h05);
    clr_ctr(0, 32'h0);
    clr_ctr(1, 32'hFFFF_FFFF);
    pulse(NUM_EVT'(1) << 5, 6);
    apb_read(ctr_addr(0), 32'd6, "R9 ctr0 shared event");
    apb_read(ctr_addr(1), 32'd6, "R9 ctr1 shared event");
    clr_ctr(0, 32'hA5A5_0001);
    apb_read(ctr_addr(0), 32'd0, "R4 ctr0 cleared by write");
    apb_read(ctr_addr(1), 32'd6, "R9 ctr1 untouched by ctr0 clear");

    // R4: clear and event on the same edge; the next edge still counts
    pulse(NUM_EVT'(1) << 5, 4);
    apb_write(ctr_addr(0), 32'h1234, NUM_EVT'(1) << 5);
    exp_cnt[0] = 1;
    exp_cnt[1] = exp_cnt[1] + 2;
    apb_read(ctr_addr(0), 32'd1, "R4 clear wins over event");
    apb_read(ctr_addr(1), DATA_W'(exp_cnt[1]), "R9 ctr1 counts during ctr0 clear");

    // R7: the write edge uses the old code, and the count is kept
    set_sel(1, 32'h03);
    clr_ctr(1, 32'h0);
    pulse(NUM_EVT'(1) << 3, 4);
    apb_write(sel_addr(1), 32'h05, NUM_EVT'(1) << 3);
    exp_sel[1] = 5;
    exp_cnt[1] = 5;
    apb_read(ctr_addr(1), 32'd5, "R7 old select on write edge");
    pulse(NUM_EVT'(1) << 3, 2);
    pulse(NUM_EVT'(1) << 5, 2);
    apb_read(ctr_addr(1), DATA_W'(exp_cnt[1]), "R7 new select applies");

    // R3: saturation
    set_sel(2, 32'h09);
    clr_ctr(2, 32'h0);
    pulse(NUM_EVT'(1) << 9, CMAX + 7);
    apb_read(ctr_addr(2), DATA_W'(CMAX), "R3 saturate at max");
    pulse(NUM_EVT'(1) << 9, 3);
    apb_read(ctr_addr(2), DATA_W'(CMAX), "R3 stays at max");
    clr_ctr(2, 32'h7);
    apb_read(ctr_addr(2), 32'd0, "R4 clear after saturation");

    // R8: unmapped and misaligned offsets
    apb_write(32'h000, 32'hFFFF_FFFF, '0);
    apb_write(32'h004, 32'hFFFF_FFFF, '0);
    apb_write(32'h028, 32'hFFFF_FFFF, '0);
    apb_write(32'h00D, 32'hFFFF_FFFF, '0);
    apb_write(32'h009, 32'hFFFF_FFFF, '0);
    apb_read(32'h000, 32'd0, "R8 offset 0x00 reads zero");
    apb_read(32'h004, 32'd0, "R8 offset 0x04 reads zero");
    apb_read(32'h028, 32'd0, "R8 offset 0x28 reads zero");
    apb_read(32'h00A, 32'd0, "R8 misaligned reads zero");
    read_all("R8 registers unchanged");

    repeat (4) @(negedge pclk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R10 reads pending: actual %0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule